// File: doc/BRIEF.md
# Hot-Swap Fault Supervisor

This block is the digital supervisor for a hot-swap power switch. It receives status bits that have already been digitized: the enable request, a standby request (active low), undervoltage lockout, overvoltage, overtemperature, a current-limit indication, a comparator that reports current through the switch, and a mode select. From these it drives a gate-enable, a request for the strong gate pulldown, and two active-low open-drain fault flags. Each flag has an output enable, so the high-impedance state can be modelled.

A counter with a programmable terminal count acts as the fault timer. The timer accumulates while the switch is in current limit and drains back to zero when the limit clears. If it reaches the terminal count, the gate is switched off. What happens next depends on the mode select. In latch mode the block holds the gate off until it is released. In retry mode it waits sixteen up-and-down timer sweeps and then tries the gate again, so a persistent overload repeats the sequence indefinitely.

The second flag reports a probable shorted switch. It fires when current flows while the gate has been commanded off by enable or overvoltage.

Top module: `hotswap_supervisor`

## Requirements
- R1: After synchronous reset the gate is off, the strong pulldown is requested, and both flags are released (output enable 0, flag value 1).
- R2: When enable and standby are high and undervoltage, overvoltage and overtemperature are all low at a clock edge, the gate is on after that edge. Any one of those conditions failing turns the gate off after the next edge.
- R3: With the gate on, the gate turns off after the edge at which current limit has been sampled high on T consecutive edges from an empty timer. T is the terminal count, and a terminal count of 0 acts as 1. From that same point the fault flag is driven (output enable 1, value 0).
- R4: When current limit is low, the timer drops by one per edge until it reaches zero. A later overload then needs only the remaining counts to expire, and an overload shorter than T never faults.
- R5: In latch mode (mode input 1) a timed-out gate stays off and the fault flag stays driven, whatever current limit, overvoltage or overtemperature do. Driving enable low releases the flag on the next edge, and driving enable high again turns the gate back on one edge later.
- R6: In latch mode, a pass through undervoltage or a pass through standby also clears a latched fault.
- R7: In retry mode (mode input 0) the gate stays off for exactly 32·T edges after a timeout, which is sixteen sweeps of T edges up and T edges down. It then turns on again. The fault flag is driven on exactly those edges.
- R8: In retry mode with current limit held high, the gate is on for T and off for 32·T out of every 33·T edges. The fault flag is the inverse of the gate throughout.
- R9: Turning the gate off through enable, standby, undervoltage, overvoltage or overtemperature never drives the fault flag. Any of these during a retry wait ends the wait and releases the flag on the next edge.
- R10: The short flag is driven one edge after a sample in which all of the following hold: current flows, undervoltage is low, standby is high, overtemperature is low, and either enable is low or overvoltage is high. Otherwise it is released one edge after the sample.
- R11: While standby is low, both flag output enables and the strong pulldown request are 0 in the same cycle. Whenever the gate is off and standby is high, the strong pulldown is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Enable request |
| stby_n_i | input | 1 | Standby request, active low |
| uvlo_i | input | 1 | Supply below undervoltage threshold |
| ov_i | input | 1 | Overvoltage comparator |
| ot_i | input | 1 | Overtemperature shutdown |
| ilim_i | input | 1 | Switch is in current limit |
| latch_mode_i | input | 1 | 1 selects latch mode, 0 selects retry mode |
| leak_i | input | 1 | Current above threshold through the switch |
| timer_term_i | input | TMR_W | Fault timer terminal count |
| gate_on_o | output | 1 | Gate enable |
| pd_strong_o | output | 1 | Strong gate pulldown request |
| fault_n_o | output | 1 | Timeout fault flag, active low |
| fault_oe_o | output | 1 | Fault flag output enable |
| short_n_o | output | 1 | Shorted switch flag, active low |
| short_oe_o | output | 1 | Short flag output enable |

## Verification
A wrong supervisor state shows at the ports within one edge. The gate or the fault flag takes a value the inputs do not explain, for example a flag during a plain disable, or a gate that stays on through a disable. A timer that miscounts shifts the timeout edge by at least one cycle. A wrong retry sweep or cycle count moves the restart edge by a multiple of T, which a 33·T-period pulse-train check exposes on the first period. The short flag and the standby gating are swept over every combination of the six inputs they depend on.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    typedef enum logic [2:0] {
        ST_OFF        = 3'd0,
        ST_ON         = 3'd1,
        ST_TIMING     = 3'd2,
        ST_LATCHED    = 3'd3,
        ST_RETRY_WAIT = 3'd4
    } sup_state_e;

    typedef enum logic [1:0] {
        TCMD_CLR   = 2'd0,
        TCMD_LIMIT = 2'd1,
        TCMD_CYCLE = 2'd2
    } tmr_cmd_e;

    typedef struct packed {
        logic en;
        logic stby_n;
        logic uvlo;
        logic ov;
        logic ot;
    } rail_stat_t;

    function automatic logic rail_blocked(rail_stat_t s);
        return !s.en || !s.stby_n || s.uvlo || s.ov || s.ot;
    endfunction

    function automatic logic short_cond(rail_stat_t s, logic leak);
        return leak && !s.uvlo && s.stby_n && !s.ot && (!s.en || s.ov);
    endfunction

    function automatic logic gate_driven(sup_state_e st);
        return (st == ST_ON) || (st == ST_TIMING);
    endfunction

    function automatic logic fault_held(sup_state_e st);
        return (st == ST_LATCHED) || (st == ST_RETRY_WAIT);
    endfunction

endpackage

// File: rtl/hsw_fault_timer.sv
module hsw_fault_timer
    import hsw_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_cmd_e         cmd_i,
    input  logic             ilim_i,
    input  logic [TMR_W-1:0] term_i,
    output logic             expire_o,
    output logic             above_one_o,
    output logic             cycle_end_o
);

    localparam logic [TMR_W-1:0] ONE   = TMR_W'(1);
    localparam logic [TMR_W-1:0] ZERO  = '0;
    localparam logic [TMR_W:0]   ONE_X = (TMR_W + 1)'(1);

    logic [TMR_W-1:0] cnt_q;
    logic             down_q;
    logic [TMR_W-1:0] term_eff;
    logic [TMR_W:0]   cnt_inc;

    assign term_eff    = (term_i == ZERO) ? ONE : term_i;
    assign cnt_inc     = {1'b0, cnt_q} + ONE_X;
    assign expire_o    = ilim_i && (cnt_inc >= {1'b0, term_eff});
    assign above_one_o = cnt_q > ONE;
    assign cycle_end_o = down_q && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= ZERO;
            down_q <= 1'b0;
        end else begin
            case (cmd_i)
                TCMD_LIMIT: begin
                    down_q <= 1'b0;
                    if (ilim_i)
                        cnt_q <= cnt_q + ONE;
                    else if (cnt_q != ZERO)
                        cnt_q <= cnt_q - ONE;
                end
                TCMD_CYCLE: begin
                    if (!down_q) begin
                        cnt_q <= cnt_q + ONE;
                        if (cnt_inc == {1'b0, term_eff})
                            down_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                        if (cnt_q == ONE)
                            down_q <= 1'b0;
                    end
                end
                default: begin
                    cnt_q  <= ZERO;
                    down_q <= 1'b0;
                end
            endcase
        end
    end

    // R4
    step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_i) != TCMD_CLR) |->
            ((cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE) ||
             (cnt_q == $past(cnt_q))));

endmodule

// File: rtl/hsw_short_detect.sv
module hsw_short_detect
    import hsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rail_stat_t stat_i,
    input  logic       leak_i,
    output logic       short_o
);

    logic short_q;

    always_ff @(posedge clk) begin
        if (rst)
            short_q <= 1'b0;
        else
            short_q <= short_cond(stat_i, leak_i);
    end

    assign short_o = short_q;

    // R10
    short_needs_leak_chk: assert property (@(posedge clk) disable iff (rst)
        short_q |-> $past(leak_i));

    // R10
    short_quiet_standby_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(stat_i.stby_n) |-> !short_q);

endmodule

// File: rtl/hsw_ctrl_fsm.sv
module hsw_ctrl_fsm
    import hsw_pkg::*;
#(
    parameter int RETRY_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  rail_stat_t stat_i,
    input  logic       ilim_i,
    input  logic       latch_mode_i,
    input  logic       expire_i,
    input  logic       above_one_i,
    input  logic       cycle_end_i,
    output tmr_cmd_e   cmd_o,
    output sup_state_e state_o
);

    localparam int RC_W = (RETRY_CYCLES > 1) ? $clog2(RETRY_CYCLES) : 1;
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(RETRY_CYCLES - 1);
    localparam logic [RC_W-1:0] RC_ONE  = RC_W'(1);

    sup_state_e      state_q, state_d;
    logic [RC_W-1:0] rcnt_q, rcnt_d;
    logic            blocked;

    assign blocked = rail_blocked(stat_i);

    always_comb begin
        state_d = state_q;
        rcnt_d  = rcnt_q;
        cmd_o   = TCMD_CLR;
        case (state_q)
            ST_OFF: begin
                if (!blocked)
                    state_d = ST_ON;
            end
            ST_ON, ST_TIMING: begin
                if (blocked) begin
                    state_d = ST_OFF;
                end else if (expire_i) begin
                    state_d = latch_mode_i ? ST_LATCHED : ST_RETRY_WAIT;
                    rcnt_d  = '0;
                end else begin
                    cmd_o   = TCMD_LIMIT;
                    state_d = (ilim_i || above_one_i) ? ST_TIMING : ST_ON;
                end
            end
            ST_LATCHED: begin
                if (!stat_i.en || !stat_i.stby_n || stat_i.uvlo)
                    state_d = ST_OFF;
            end
            ST_RETRY_WAIT: begin
                if (blocked) begin
                    state_d = ST_OFF;
                    rcnt_d  = '0;
                end else begin
                    cmd_o = TCMD_CYCLE;
                    if (cycle_end_i) begin
                        if (rcnt_q == RC_LAST) begin
                            state_d = ST_ON;
                            rcnt_d  = '0;
                        end else begin
                            rcnt_d = rcnt_q + RC_ONE;
                        end
                    end
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            rcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            rcnt_q  <= rcnt_d;
        end
    end

    assign state_o = state_q;

    // R2
    gate_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_driven(state_q) && rail_blocked(stat_i)) |=> (state_q == ST_OFF));

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LATCHED && stat_i.en && stat_i.stby_n && !stat_i.uvlo)
            |=> (state_q == ST_LATCHED));

    // R7
    retry_count_chk: assert property (@(posedge clk) disable iff (rst)
        (rcnt_q != $past(rcnt_q)) |-> ($past(state_q) == ST_RETRY_WAIT));

endmodule

// File: rtl/hotswap_supervisor.sv
module hotswap_supervisor
    import hsw_pkg::*;
#(
    parameter int TMR_W        = 8,
    parameter int RETRY_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             stby_n_i,
    input  logic             uvlo_i,
    input  logic             ov_i,
    input  logic             ot_i,
    input  logic             ilim_i,
    input  logic             latch_mode_i,
    input  logic             leak_i,
    input  logic [TMR_W-1:0] timer_term_i,
    output logic             gate_on_o,
    output logic             pd_strong_o,
    output logic             fault_n_o,
    output logic             fault_oe_o,
    output logic             short_n_o,
    output logic             short_oe_o
);

    rail_stat_t stat;
    tmr_cmd_e   tmr_cmd;
    sup_state_e state;
    logic       expire, above_one, cycle_end, short_q;

    assign stat = '{en: en_i, stby_n: stby_n_i, uvlo: uvlo_i, ov: ov_i, ot: ot_i};

    hsw_fault_timer #(.TMR_W(TMR_W)) timer_i (
        .clk        (clk),
        .rst        (rst),
        .cmd_i      (tmr_cmd),
        .ilim_i     (ilim_i),
        .term_i     (timer_term_i),
        .expire_o   (expire),
        .above_one_o(above_one),
        .cycle_end_o(cycle_end)
    );

    hsw_ctrl_fsm #(.RETRY_CYCLES(RETRY_CYCLES)) fsm_i (
        .clk         (clk),
        .rst         (rst),
        .stat_i      (stat),
        .ilim_i      (ilim_i),
        .latch_mode_i(latch_mode_i),
        .expire_i    (expire),
        .above_one_i (above_one),
        .cycle_end_i (cycle_end),
        .cmd_o       (tmr_cmd),
        .state_o     (state)
    );

    hsw_short_detect short_i (
        .clk    (clk),
        .rst    (rst),
        .stat_i (stat),
        .leak_i (leak_i),
        .short_o(short_q)
    );

    assign gate_on_o   = gate_driven(state);
    assign pd_strong_o = !gate_on_o && stby_n_i;
    assign fault_oe_o  = fault_held(state) && stby_n_i;
    assign fault_n_o   = !fault_oe_o;
    assign short_oe_o  = short_q && stby_n_i;
    assign short_n_o   = !short_oe_o;

    // R3
    flag_gate_excl_chk: assert property (@(posedge clk) disable iff (rst)
        fault_oe_o |-> !gate_on_o);

    // R11
    standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !stby_n_i |-> (!fault_oe_o && !short_oe_o && !pd_strong_o));

endmodule

// File: tb/hotswap_supervisor_tb.sv
module hotswap_supervisor_tb_top;

    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          en, stby_n, uvlo, ov, ot, ilim, latch_mode, leak;
    logic [TW-1:0] term;
    logic          gate_on, pd_strong, fault_n, fault_oe, short_n, short_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hotswap_supervisor #(.TMR_W(TW), .RETRY_CYCLES(16)) dut_i (
        .clk(clk), .rst(rst), .en_i(en), .stby_n_i(stby_n), .uvlo_i(uvlo),
        .ov_i(ov), .ot_i(ot), .ilim_i(ilim), .latch_mode_i(latch_mode),
        .leak_i(leak), .timer_term_i(term), .gate_on_o(gate_on),
        .pd_strong_o(pd_strong), .fault_n_o(fault_n), .fault_oe_o(fault_oe),
        .short_n_o(short_n), .short_oe_o(short_oe)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_outs(string req, logic g, logic f);
        chk({req, " gate"}, gate_on, g);
        chk({req, " fault_oe"}, fault_oe, f);
        chk({req, " fault_n"}, fault_n, !f);
        chk({req, " pd_strong"}, pd_strong, !g && stby_n);
    endtask

    task automatic set_good();
        en = 1'b1; stby_n = 1'b1; uvlo = 1'b0; ov = 1'b0; ot = 1'b0;
        ilim = 1'b0; leak = 1'b0;
    endtask

    task automatic restart();
        set_good();
        en = 1'b0;
        step();
        en = 1'b1;
        step();
        chk_outs("R2 restart", 1'b1, 1'b0);
    endtask

    task automatic trip(int te, string req);
        ilim = 1'b1;
        for (int k = 1; k < te; k++) begin
            step();
            chk_outs({req, " before expiry"}, 1'b1, 1'b0);
        end
        step();
        chk_outs({req, " at expiry"}, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int terms [5] = '{0, 1, 2, 3, 5};
        set_good();
        latch_mode = 1'b1;
        term = TW'(3);
        rst = 1'b1;
        step();
        step();
        // R1 reset state
        chk_outs("R1", 1'b0, 1'b0);
        chk("R1 short_oe", short_oe, 1'b0);
        chk("R1 short_n", short_n, 1'b1);
        rst = 1'b0;
        step();
        chk_outs("R2 first enable", 1'b1, 1'b0);

        // R2 R9 R10 R11 sweep over all rail/leak combinations
        for (int v = 0; v < 64; v++) begin
            logic good, sh;
            {leak, en, ov, uvlo, ot, stby_n} = 6'(v);
            #1;
            if (!stby_n) begin
                chk("R11 standby fault_oe", fault_oe, 1'b0);
                chk("R11 standby short_oe", short_oe, 1'b0);
                chk("R11 standby pd_strong", pd_strong, 1'b0);
            end
            good = en && stby_n && !uvlo && !ov && !ot;
            sh   = leak && !uvlo && stby_n && !ot && (!en || ov);
            step();
            chk("R2 sweep gate", gate_on, good);
            chk("R9 sweep fault_oe", fault_oe, 1'b0);
            chk("R10 sweep short_oe", short_oe, sh);
            chk("R10 sweep short_n", short_n, !sh);
            chk("R11 sweep pd_strong", pd_strong, !good && stby_n);
        end

        // R3 R5 R7 R8 for several terminal counts
        foreach (terms[i]) begin
            int te;
            te = (terms[i] == 0) ? 1 : terms[i];
            term = TW'(terms[i]);
            latch_mode = 1'b1;
            restart();
            trip(te, "R3 latch");
            ilim = 1'b0;
            for (int k = 0; k < 40; k++) begin
                step();
                chk_outs("R5 latched hold", 1'b0, 1'b1);
            end
            ov = 1'b1; ot = 1'b1; ilim = 1'b1;
            step();
            step();
            ov = 1'b0; ot = 1'b0; ilim = 1'b0;
            step();
            chk_outs("R5 latched after ov/ot", 1'b0, 1'b1);
            en = 1'b0;
            step();
            chk_outs("R5 enable low releases", 1'b0, 1'b0);
            en = 1'b1;
            step();
            chk_outs("R5 enable high restarts", 1'b1, 1'b0);

            latch_mode = 1'b0;
            trip(te, "R3 retry");
            ilim = 1'b0;
            for (int k = 1; k < 32 * te; k++) begin
                step();
                chk_outs("R7 retry wait", 1'b0, 1'b1);
            end
            step();
            chk_outs("R7 retry restart", 1'b1, 1'b0);
            ilim = 1'b1;
            for (int n = 1; n <= 2 * 33 * te; n++) begin
                logic g;
                step();
                g = (n % (33 * te)) < te;
                chk_outs("R8 pulse train", g, !g);
            end
        end

        // R4 timer drains while limit is low
        latch_mode = 1'b1;
        term = TW'(4);
        restart();
        ilim = 1'b1;
        repeat (3) step();
        chk_outs("R4 three limit cycles", 1'b1, 1'b0);
        ilim = 1'b0;
        repeat (4) step();
        ilim = 1'b1;
        repeat (3) step();
        chk_outs("R4 drained then three", 1'b1, 1'b0);
        ilim = 1'b0;
        step();
        ilim = 1'b1;
        step();
        chk_outs("R4 partial drain first", 1'b1, 1'b0);
        step();
        chk_outs("R4 partial drain expiry", 1'b0, 1'b1);

        // R6 clear latched fault through undervoltage and standby
        ilim = 1'b0;
        uvlo = 1'b1;
        step();
        chk_outs("R6 uvlo releases", 1'b0, 1'b0);
        uvlo = 1'b0;
        step();
        chk_outs("R6 uvlo restart", 1'b1, 1'b0);
        trip(4, "R6 trip");
        ilim = 1'b0;
        stby_n = 1'b0;
        #1;
        chk_outs("R6 standby immediate", 1'b0, 1'b0);
        step();
        stby_n = 1'b1;
        step();
        chk_outs("R6 standby restart", 1'b1, 1'b0);

        // R9 disable during retry wait
        latch_mode = 1'b0;
        trip(4, "R9 trip");
        ilim = 1'b0;
        repeat (5) step();
        ov = 1'b1;
        step();
        chk_outs("R9 ov cancels wait", 1'b0, 1'b0);
        ov = 1'b0;
        step();
        chk_outs("R9 ov cleared restart", 1'b1, 1'b0);
        trip(4, "R9 trip2");
        ilim = 1'b0;
        ot = 1'b1;
        step();
        chk_outs("R9 ot cancels wait", 1'b0, 1'b0);
        ot = 1'b0;
        step();
        chk_outs("R9 ot cleared restart", 1'b1, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule